// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

A single-port synchronous memory with a 36-bit word, split into four 9-bit byte lanes. It takes a new read or write command on every clock edge. Reads and writes use the same two-clock pipeline, so the data bus never needs an idle cycle when it changes direction. A read command returns its word on `rdata` after two enabled clock edges. A write command takes its word from `wdata` at the second enabled edge after the command, so a read and a write issued on neighbouring cycles use the data buses in the same slots.

Each command either loads a fresh address or advances a 2-bit burst counter, which gives 4-beat bursts. The low two address bits follow either a linear wrap-around order or an interleaved XOR order. A command is accepted only when all three chip enables are high; any other load cycle is a deselect. When the clock enable is low, every pipeline register holds its value. A read that hits an address whose write is still in flight gets that write's enabled lanes merged into the returned word.

Top module: `zbt_sram`

## Requirements
- R1: A synchronous active-high reset drives `rdata` to 0 and discards every command still in the pipeline. A read issued just before reset never appears on `rdata`.
- R2: A read accepted at enabled edge N drives `rdata` after enabled edge N+2. `rdata` keeps its value in every cycle where no read completes.
- R3: A write accepted at enabled edge N takes its word from `wdata` at enabled edge N+2. Reads and writes may alternate on consecutive cycles with no idle cycle between them.
- R4: During a write, `lane_we[i]` enables storing `wdata[9*i+8:9*i]`. Lanes whose enable is low keep their stored bits.
- R5: A read accepted one cycle after a write to the same address returns the write's enabled lanes merged over the older stored word.
- R6: A load cycle (`adv`=0) is accepted only if `ce_a`, `ce_b` and `ce_c` are all 1. Otherwise it is a deselect: nothing is written and `rdata` is not updated.
- R7: While `cke` is 0, all pipeline and burst state is held. Command inputs and `wdata` in that cycle are ignored, and `rdata` stays unchanged.
- R8: When `adv`=1, the command repeats the operation (read, write or deselect) of the last load and ignores `addr`, `we` and the chip enables. `lane_we` is still sampled on each beat. Address bits above bit 1 stay those of the load.
- R9: With `ord_lin`=1 at the load, beat k (k=0..3, repeating) uses low address bits (start+k) mod 4.
- R10: With `ord_lin`=0 at the load, beat k uses low address bits start XOR k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; 0 holds all state |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c | input | 1 | Chip enable, active high |
| we | input | 1 | 1 = write, 0 = read (load cycles only) |
| adv | input | 1 | 1 = advance the burst, 0 = load `addr` |
| ord_lin | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| addr | input | AW | Word address for load cycles |
| lane_we | input | NL | Per-lane write enable |
| wdata | input | NL*LW | Write data, taken two enabled clocks after its command |
| rdata | output | NL*LW | Registered read data |

## Verification
The bench issues a partial-lane write followed at once by a read of the same address. A design without forwarding would return the stale word, and one with faulty forwarding would corrupt lanes that were never written. It runs bursts from an odd start address, where linear and interleaved orders differ, so a swapped or wrongly wrapped counter returns the wrong beat. It holds `cke` low in the middle of a read with conflicting junk on the inputs, clears each chip enable in turn during a write, and resets the block with a read in flight. These cases expose pipelines that slip on a stall, deselects that still write, and a reset that leaves a stale read in the pipeline.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic {
    ORD_XOR = 1'b0,
    ORD_WRAP = 1'b1
  } burst_ord_e;

  // Low two address bits for burst beat k starting from start.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] k,
                                         input burst_ord_e ord);
    logic [1:0] r;
    if (ord == ORD_WRAP) r = start + k;
    else                 r = start ^ k;
    return r;
  endfunction

endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage #(
  parameter int AW = 6,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke,
  input  logic          ce_all,
  input  logic          we,
  input  logic          adv,
  input  logic          ord_lin,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] lane_we,
  output logic          s1_vld,
  output logic          s1_we,
  output logic [AW-1:0] s1_addr,
  output logic [NL-1:0] s1_lanes
);
  import zbt_pkg::*;

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nxt;
  logic          op_vld_q;
  logic          op_we_q;
  burst_ord_e    ord_q;
  logic [1:0]    lo_nxt;

  always_comb begin
    cnt_nxt = cnt_q + 2'd1;
    lo_nxt  = beat_lo(base_q[1:0], cnt_nxt, ord_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      cnt_q    <= '0;
      op_vld_q <= 1'b0;
      op_we_q  <= 1'b0;
      ord_q    <= ORD_XOR;
      s1_vld   <= 1'b0;
      s1_we    <= 1'b0;
      s1_addr  <= '0;
      s1_lanes <= '0;
    end else if (cke) begin
      s1_lanes <= lane_we;
      if (!adv) begin
        base_q   <= addr;
        cnt_q    <= 2'd0;
        op_vld_q <= ce_all;
        op_we_q  <= we;
        ord_q    <= burst_ord_e'(ord_lin);
        s1_vld   <= ce_all;
        s1_we    <= we;
        s1_addr  <= addr;
      end else begin
        cnt_q    <= cnt_nxt;
        s1_vld   <= op_vld_q;
        s1_we    <= op_we_q;
        s1_addr  <= {base_q[AW-1:2], lo_nxt};
      end
    end
  end

endmodule

// File: rtl/zbt_mem_core.sv
module zbt_mem_core #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW = NL * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          cke,
  input  logic          s1_vld,
  input  logic          s1_we,
  input  logic [AW-1:0] s1_addr,
  input  logic          s2_vld,
  input  logic          s2_we,
  input  logic [AW-1:0] s2_addr,
  input  logic [NL-1:0] s2_lanes,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_word,
  output logic [NL-1:0] fwd_mask,
  output logic [DW-1:0] fwd_data
);

  logic [DW-1:0] mem [DEPTH];
  logic          wr_go;
  logic          hit;

  always_comb begin
    wr_go = s2_vld && s2_we;
    hit   = wr_go && s1_vld && !s1_we && (s1_addr == s2_addr);
  end

  // Byte-lane write port, read-before-write port: block RAM friendly.
  always_ff @(posedge clk) begin
    if (cke) begin
      if (wr_go) begin
        for (int i = 0; i < NL; i++) begin
          if (s2_lanes[i]) mem[s2_addr][i*LW +: LW] <= wdata[i*LW +: LW];
        end
      end
      rd_word <= mem[s1_addr];
    end
  end

  // Capture the write landing this edge for a read that follows it directly.
  always_ff @(posedge clk) begin
    if (cke) begin
      fwd_mask <= hit ? s2_lanes : '0;
      fwd_data <= wdata;
    end
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9,
  localparam int DW = NL * LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke,
  input  logic          ce_a,
  input  logic          ce_b,
  input  logic          ce_c,
  input  logic          we,
  input  logic          adv,
  input  logic          ord_lin,
  input  logic [AW-1:0] addr,
  input  logic [NL-1:0] lane_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic          s1_vld, s1_we;
  logic [AW-1:0] s1_addr;
  logic [NL-1:0] s1_lanes;
  logic          s2_vld, s2_we;
  logic [AW-1:0] s2_addr;
  logic [NL-1:0] s2_lanes;
  logic [DW-1:0] rd_word, fwd_data, merged;
  logic [NL-1:0] fwd_mask;
  logic          rd_done;

  zbt_cmd_stage #(.AW(AW), .NL(NL)) u_cmd (
    .clk(clk), .rst(rst), .cke(cke),
    .ce_all(ce_a & ce_b & ce_c), .we(we), .adv(adv), .ord_lin(ord_lin),
    .addr(addr), .lane_we(lane_we),
    .s1_vld(s1_vld), .s1_we(s1_we), .s1_addr(s1_addr), .s1_lanes(s1_lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld   <= 1'b0;
      s2_we    <= 1'b0;
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else if (cke) begin
      s2_vld   <= s1_vld;
      s2_we    <= s1_we;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

  zbt_mem_core #(.AW(AW), .NL(NL), .LW(LW)) u_mem (
    .clk(clk), .cke(cke),
    .s1_vld(s1_vld), .s1_we(s1_we), .s1_addr(s1_addr),
    .s2_vld(s2_vld), .s2_we(s2_we), .s2_addr(s2_addr), .s2_lanes(s2_lanes),
    .wdata(wdata),
    .rd_word(rd_word), .fwd_mask(fwd_mask), .fwd_data(fwd_data)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign merged[g*LW +: LW] = fwd_mask[g] ? fwd_data[g*LW +: LW]
                                            : rd_word[g*LW +: LW];
  end

  assign rd_done = s2_vld && !s2_we;

  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (cke && rd_done)  rdata <= merged;
  end

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          cke,
  input logic          adv,
  input logic          ce_all,
  input logic          s1_vld,
  input logic          s1_we,
  input logic          rd_done,
  input logic [DW-1:0] rdata
);

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> rdata == '0);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    !cke |=> $stable(rdata));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (cke && !rd_done) |=> $stable(rdata));

  a_r6_deselect: assert property (@(posedge clk) disable iff (rst)
    (cke && !adv && !ce_all) |=> !s1_vld);

  a_r8_adv_repeats_op: assert property (@(posedge clk) disable iff (rst)
    (cke && adv) |=> (s1_vld == $past(s1_vld)) && (s1_we == $past(s1_we)));

endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .adv(adv),
  .ce_all(ce_a & ce_b & ce_c),
  .s1_vld(s1_vld), .s1_we(s1_we), .rd_done(rd_done), .rdata(rdata)
);

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  localparam logic [DW-1:0] VA = 36'h123456789;
  localparam logic [DW-1:0] VB = 36'hFEDCBA987;
  localparam logic [DW-1:0] VC = 36'h9ABCDEF01;
  localparam logic [DW-1:0] VM = 36'h123CD6701; // VA with lanes 0,2 from VC
  localparam logic [DW-1:0] D0 = 36'h0000000A0;
  localparam logic [DW-1:0] D1 = 36'h0000000A1;
  localparam logic [DW-1:0] D2 = 36'h0000000A2;
  localparam logic [DW-1:0] D3 = 36'h0000000A3;

  typedef struct packed {
    logic          sel;
    logic          we;
    logic          adv;
    logic          lin;
    logic [AW-1:0] addr;
    logic [NL-1:0] lanes;
    logic [DW-1:0] wd;
    logic          chk;
    logic [DW-1:0] exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,6'd5, 4'hF,36'h0,1'b0,36'h0}, // W 5
    '{1'b1,1'b1,1'b0,1'b0,6'd6, 4'hF,36'h0,1'b0,36'h0}, // W 6
    '{1'b1,1'b0,1'b0,1'b0,6'd5, 4'hF,VA,   1'b0,36'h0}, // R 5, data for W 5
    '{1'b1,1'b0,1'b0,1'b0,6'd6, 4'hF,VB,   1'b0,36'h0}, // R 6, data for W 6
    '{1'b1,1'b1,1'b0,1'b0,6'd5, 4'h5,36'h0,1'b1,VA},   // W 5 lanes 0,2 ; R2/R3
    '{1'b1,1'b0,1'b0,1'b0,6'd5, 4'hF,36'h0,1'b1,VB},   // R 5 right after W
    '{1'b1,1'b0,1'b0,1'b0,6'd6, 4'hF,VC,   1'b0,36'h0}, // R 6, data for lane W
    '{1'b0,1'b0,1'b0,1'b0,6'd0, 4'hF,36'h0,1'b1,VM},   // R4/R5 merged
    '{1'b0,1'b0,1'b0,1'b0,6'd0, 4'hF,36'h0,1'b1,VB},
    '{1'b1,1'b1,1'b0,1'b1,6'd8, 4'hF,36'h0,1'b0,36'h0}, // W burst linear from 8
    '{1'b1,1'b1,1'b1,1'b1,6'd0, 4'hF,36'h0,1'b0,36'h0},
    '{1'b1,1'b1,1'b1,1'b1,6'd0, 4'hF,D0,   1'b0,36'h0},
    '{1'b1,1'b1,1'b1,1'b1,6'd0, 4'hF,D1,   1'b0,36'h0},
    '{1'b1,1'b0,1'b0,1'b0,6'd9, 4'hF,D2,   1'b0,36'h0}, // R burst xor from 9
    '{1'b1,1'b0,1'b1,1'b0,6'd0, 4'hF,D3,   1'b0,36'h0},
    '{1'b1,1'b0,1'b1,1'b0,6'd0, 4'hF,36'h0,1'b1,D1},   // R10 beat 0: 9
    '{1'b1,1'b0,1'b1,1'b0,6'd0, 4'hF,36'h0,1'b1,D0},   // R10 beat 1: 8
    '{1'b0,1'b0,1'b0,1'b0,6'd0, 4'hF,36'h0,1'b1,D3},   // R10 beat 2: 11
    '{1'b0,1'b0,1'b0,1'b0,6'd0, 4'hF,36'h0,1'b1,D2},   // R10 beat 3: 10
    '{1'b1,1'b0,1'b0,1'b1,6'd9, 4'hF,36'h0,1'b0,36'h0}, // R burst linear from 9
    '{1'b1,1'b0,1'b1,1'b1,6'd0, 4'hF,36'h0,1'b0,36'h0},
    '{1'b1,1'b0,1'b1,1'b1,6'd0, 4'hF,36'h0,1'b1,D1},   // R9 beat 0: 9
    '{1'b1,1'b0,1'b1,1'b1,6'd0, 4'hF,36'h0,1'b1,D2},   // R9 beat 1: 10
    '{1'b0,1'b0,1'b0,1'b0,6'd0, 4'hF,36'h0,1'b1,D3},   // R9 beat 2: 11
    '{1'b0,1'b0,1'b0,1'b0,6'd0, 4'hF,36'h0,1'b1,D0}    // R9 beat 3 wraps: 8
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cke = 1'b1;
  logic          ce_a = 1'b0, ce_b = 1'b0, ce_c = 1'b0;
  logic          we = 1'b0, adv = 1'b0, ord_lin = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] lane_we = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zbt_sram #(.AW(AW), .NL(NL), .LW(LW)) i_zbt_sram (
    .clk(clk), .rst(rst), .cke(cke), .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c),
    .we(we), .adv(adv), .ord_lin(ord_lin), .addr(addr), .lane_we(lane_we),
    .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] exp);
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  // Apply one cycle of inputs, clock once, return 1 ns after the edge.
  task automatic cyc(input logic c, input logic s, input logic w, input logic a,
                     input logic l, input logic [AW-1:0] ad,
                     input logic [NL-1:0] ln, input logic [DW-1:0] d);
    cke = c; ce_a = s; ce_b = s; ce_c = s; we = w; adv = a; ord_lin = l;
    addr = ad; lane_we = ln; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic nop();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, TBL[i].sel, TBL[i].we, TBL[i].adv, TBL[i].lin,
          TBL[i].addr, TBL[i].lanes, TBL[i].wd);
      if (TBL[i].chk) check($sformatf("R2 table row %0d", i), TBL[i].exp);
    end

    // R7: stall in the middle of a read of address 6, junk on every input.
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd6, 4'hF, '0);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'd6, 4'hF, '1);
      check("R7 stall holds rdata", D0);
    end
    nop();
    check("R7 one enabled edge after stall", D0);
    nop();
    check("R7 read completes after two enabled edges", VB);

    // R6: a write with any single chip enable low must not store.
    for (int k = 0; k < 3; k++) begin
      cke = 1'b1; ce_a = (k != 0); ce_b = (k != 1); ce_c = (k != 2);
      we = 1'b1; adv = 1'b0; addr = 6'd6; lane_we = 4'hF; wdata = '0;
      @(posedge clk); #1;
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 4'hF, '1);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 4'hF, '1);
      check("R6 deselect leaves rdata", VB);
    end
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd6, 4'hF, '0);
    nop();
    nop();
    check("R6 deselected writes did not store", VB);

    // R3: write then read on back-to-back cycles, other address, no gap.
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'd20, 4'hF, '0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd5, 4'hF, '0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd20, 4'hF, VA);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0);
    check("R3 read after write, other address", VM);
    nop();
    check("R3 write data taken two clocks late", VA);

    // R1: reset with a read in flight flushes it.
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd6, 4'hF, '0);
    rst = 1'b1;
    nop();
    check("R1 reset clears rdata", '0);
    rst = 1'b0;
    nop();
    nop();
    check("R1 flushed read never appears", '0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule